// File: doc/BRIEF.md
# Cache Contents Address Logger

The logger records which cache lines are resident in a modelled cache and writes their physical line addresses out to a table in memory. A later restore step can then prefetch the same working set. Software starts a log by presenting one 64-bit command word. The block then reads a tag-valid snapshot port one line index per cycle. It emits one 64-bit write request per valid line on a valid/ready memory write port, and places the entries at consecutive 8-byte slots above the table base.

There are two log modes. The first logs only the first-level lines into a 32 KB table. The second logs the first-level lines followed by the second-level lines into a 128 KB table. The same command word is also used to cancel a log that is running. While a log runs, `busy` is high. When the log ends, either normally or by cancellation, `done` pulses for one cycle and `entry_count` holds the number of entries the memory port accepted.

Top module: `cache_addr_logger`

## Requirements
- R1: The command field `cmd_word[55:54]` selects the action. 2'b10 starts a first-level log, which walks indices 0 to 4095 and uses a table capacity of 4096 entries. 2'b01 starts a two-level log, which walks indices 0 to 16383 and uses a capacity of 16384 entries. 2'b11 aborts a running log. 2'b00 does nothing. The table base is `cmd_word[47:14]` followed by 14 zero bits.
- R2: A start command whose base has any of bits 16:14 set is not 128 KB aligned. It is rejected: `busy` stays low, no write is issued and `entry_count` is unchanged.
- R3: Only lines whose `snap_valid` is high are logged. They are logged in ascending index order, and the entry data equals `snap_line` for that index.
- R4: Entry n is written to address base + 8*n, so every request address has bits 2:0 at zero.
- R5: After the last valid line, one terminator entry of all ones is written if fewer entries than the table capacity have been issued. When the table is already full, no terminator is written.
- R6: While `mem_wr_valid` is high and `mem_wr_ready` is low, the request, its address and its data hold steady. No entry is lost or repeated.
- R7: At the end of a log, `done` is high for exactly one cycle and `busy` is low in that cycle. `entry_count` then equals the number of accepted writes, terminator included.
- R8: An abort command while busy ends the log at the next clock edge. In the following cycle `busy` is low, `done` is high and `mem_wr_valid` is low: any request not yet accepted is withdrawn. `entry_count` equals the number of writes accepted.
- R9: A no-op command or an abort command while idle changes nothing: there is no `done` pulse, `busy` stays low and `entry_count` holds.
- R10: A start command or a no-op command while busy is ignored. The running log continues with its original base and mode.
- R11: After reset, `busy`, `done` and `mem_wr_valid` are low and `entry_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 64 | Command: control field at 55:54, table base at 47:14 |
| snap_idx | output | 14 | Line index being read from the cache snapshot |
| snap_valid | input | 1 | Line at `snap_idx` holds valid data (same cycle) |
| snap_line | input | 64 | Physical line address of the line at `snap_idx` |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Memory accepts the request at this edge |
| mem_wr_addr | output | 48 | Byte address of the table entry |
| mem_wr_data | output | 64 | Entry value |
| busy | output | 1 | A log is running |
| done | output | 1 | One-cycle pulse when a log ends |
| entry_count | output | 15 | Entries accepted by memory in the current or last log |

## Verification
An accepted command raises `busy` one cycle later. The first write request can appear two cycles after the command. `done` rises one cycle after the last write is accepted, and one cycle after an abort command. The bench drives inputs and samples outputs on the falling edge. It sets `mem_wr_ready` and judges a handshake at the same falling edge, so it counts exactly the transfers that complete at the next rising edge. It checks the status outputs at the first falling edge after the edge on which they are due, and again one cycle later to confirm that the pulse has ended.

// File: rtl/cal_pkg.sv
// Shared constants and types for the cache address logger.
// Assumes 48-bit physical addresses and 64-bit table entries.
package cal_pkg;
    localparam int ADDR_W   = 48;
    localparam int WORD_W   = 64;
    localparam int CTL_LSB  = 54;
    localparam int BASE_LSB = 14;

    typedef enum logic [1:0] {
        CTL_NOP   = 2'b00,
        CTL_BOTH  = 2'b01,
        CTL_FIRST = 2'b10,
        CTL_ABORT = 2'b11
    } log_ctl_e;

    typedef struct packed {
        logic              start;
        logic              abort;
        logic              both;
        logic [ADDR_W-1:0] base;
    } cmd_req_t;
endpackage

// File: rtl/cal_cmd_dec.sv
// Command decoder: turns a command word into start/abort requests.
// Assumes the caller supplies the current busy state. Misaligned starts
// and commands that do not fit the current state are dropped.
module cal_cmd_dec
    import cal_pkg::*;
#(
    parameter int ALIGN_LSB = 17
) (
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              busy,
    output cmd_req_t          req
);
    log_ctl_e ctl;
    logic     aligned;
    logic     unused_bits;

    // Extract the control field and check the base alignment.
    always_comb begin
        ctl     = log_ctl_e'(cmd_word[CTL_LSB+1:CTL_LSB]);
        aligned = (cmd_word[ALIGN_LSB-1:BASE_LSB] == '0);
    end

    // Form the request seen by the walker and the writer.
    always_comb begin
        req.start = cmd_valid && !busy && aligned &&
                    (ctl == CTL_FIRST || ctl == CTL_BOTH);
        req.abort = cmd_valid && busy && (ctl == CTL_ABORT);
        req.both  = (ctl == CTL_BOTH);
        req.base  = {cmd_word[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    end

    assign unused_bits = ^{cmd_word[WORD_W-1:CTL_LSB+2],
                           cmd_word[CTL_LSB-1:ADDR_W],
                           cmd_word[BASE_LSB-1:0]};
endmodule

// File: rtl/cal_walker.sv
// Line walker: steps the snapshot index, requests a table entry for each
// valid line, adds the terminator, and ends the log.
// Assumes the writer reports slot_free in the same cycle as it accepts loads.
module cal_walker #(
    parameter int L1_LINES  = 4096,
    parameter int L2_LINES  = 12288,
    parameter int SMALL_ENT = 4096,
    parameter int LARGE_ENT = 16384,
    parameter int CNT_W     = 15,
    parameter int IDX_W     = 14,
    parameter int WALK_W    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             both,
    input  logic             slot_free,
    input  logic             req_valid,
    input  logic             snap_valid,
    input  logic [CNT_W-1:0] issued,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] snap_idx,
    output logic             load_line,
    output logic             load_term
);
    logic [WALK_W-1:0] idx;
    logic [WALK_W-1:0] limit;
    logic [CNT_W-1:0]  cap;
    logic              both_q;
    logic              term_done;
    logic              walking;
    logic              at_end;
    logic              full;
    logic              finish;

    // Per-mode walk limit and table capacity.
    always_comb begin
        limit = both_q ? WALK_W'(L1_LINES + L2_LINES) : WALK_W'(L1_LINES);
        cap   = both_q ? CNT_W'(LARGE_ENT) : CNT_W'(SMALL_ENT);
    end

    // Phase decode and load requests toward the writer.
    always_comb begin
        walking   = busy && (idx < limit);
        at_end    = busy && (idx == limit);
        full      = (issued >= cap);
        load_line = walking && slot_free && snap_valid;
        load_term = at_end && !term_done && !full && slot_free;
        finish    = at_end && term_done && !req_valid;
    end

    assign snap_idx = idx[IDX_W-1:0];

    // Walk state, terminator tracking and the end-of-log pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            idx       <= '0;
            both_q    <= 1'b0;
            term_done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (start) begin
                busy      <= 1'b1;
                idx       <= '0;
                both_q    <= both;
                term_done <= 1'b0;
            end else if (busy) begin
                if (walking && slot_free) begin
                    idx <= idx + WALK_W'(1);
                end
                if (at_end && !term_done && (slot_free || full)) begin
                    term_done <= 1'b1;
                end
                if (finish) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cal_writer.sv
// Entry writer: a single request register on the valid/ready port.
// Computes each entry address from the base and the issue pointer, and
// counts accepted transfers. Abort withdraws a request not yet accepted.
module cal_writer #(
    parameter int ADDR_W = 48,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] base,
    input  logic              load_line,
    input  logic              load_term,
    input  logic [63:0]       line_data,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_data,
    output logic [CNT_W-1:0]  issued,
    output logic [CNT_W-1:0]  accepted,
    output logic              slot_free
);
    logic [ADDR_W-1:0] base_q;
    logic              xfer;

    // A transfer completes when valid meets ready.
    always_comb begin
        xfer      = mem_valid && mem_ready;
        slot_free = !mem_valid || mem_ready;
    end

    // Request register, issue pointer and accepted-entry counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            issued    <= '0;
            accepted  <= '0;
        end else if (start) begin
            base_q    <= base;
            mem_valid <= 1'b0;
            issued    <= '0;
            accepted  <= '0;
        end else begin
            if (xfer) begin
                accepted <= accepted + CNT_W'(1);
            end
            if (abort) begin
                mem_valid <= 1'b0;
            end else if (load_line || load_term) begin
                mem_valid <= 1'b1;
                mem_addr  <= base_q + ADDR_W'({issued, 3'b000});
                mem_data  <= load_term ? '1 : line_data;
                issued    <= issued + CNT_W'(1);
            end else if (xfer) begin
                mem_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cache_addr_logger.sv
// Top level: logs the addresses of valid cache lines into a memory table.
// Assumes the snapshot port answers combinationally for snap_idx.
module cache_addr_logger
    import cal_pkg::*;
#(
    parameter int SMALL_TBL_BYTES = 32768,
    parameter int LARGE_TBL_BYTES = 131072,
    parameter int L1_LINES        = 4096,
    parameter int L2_LINES        = 12288,
    localparam int SMALL_ENT = SMALL_TBL_BYTES / 8,
    localparam int LARGE_ENT = LARGE_TBL_BYTES / 8,
    localparam int ALIGN_LSB = $clog2(LARGE_TBL_BYTES),
    localparam int CNT_W     = $clog2(LARGE_ENT + 1),
    localparam int IDX_W     = $clog2(L1_LINES + L2_LINES),
    localparam int WALK_W    = $clog2(L1_LINES + L2_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [63:0]       cmd_word,
    output logic [IDX_W-1:0]  snap_idx,
    input  logic              snap_valid,
    input  logic [63:0]       snap_line,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  entry_count
);
    cmd_req_t         req;
    logic             load_line;
    logic             load_term;
    logic             slot_free;
    logic [CNT_W-1:0] issued;

    cal_cmd_dec #(.ALIGN_LSB(ALIGN_LSB)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .busy      (busy),
        .req       (req)
    );

    cal_walker #(
        .L1_LINES  (L1_LINES),
        .L2_LINES  (L2_LINES),
        .SMALL_ENT (SMALL_ENT),
        .LARGE_ENT (LARGE_ENT),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W),
        .WALK_W    (WALK_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req.start),
        .abort      (req.abort),
        .both       (req.both),
        .slot_free  (slot_free),
        .req_valid  (mem_wr_valid),
        .snap_valid (snap_valid),
        .issued     (issued),
        .busy       (busy),
        .done       (done),
        .snap_idx   (snap_idx),
        .load_line  (load_line),
        .load_term  (load_term)
    );

    cal_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req.start),
        .abort     (req.abort),
        .base      (req.base),
        .load_line (load_line),
        .load_term (load_term),
        .line_data (snap_line),
        .mem_ready (mem_wr_ready),
        .mem_valid (mem_wr_valid),
        .mem_addr  (mem_wr_addr),
        .mem_data  (mem_wr_data),
        .issued    (issued),
        .accepted  (entry_count),
        .slot_free (slot_free)
    );
endmodule

// File: rtl/cal_checker.sv
// Protocol and status properties for the cache address logger, bound to
// the top. Tracks the last accepted address to check the entry stride.
module cal_checker #(
    parameter int ADDR_W = 48,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_ctl,
    input logic              busy,
    input logic              done,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [63:0]       mem_wr_data,
    input logic [CNT_W-1:0]  entry_count
);
    logic [ADDR_W-1:0] last_addr;
    logic              have_prev;
    logic              abort_cmd;

    assign abort_cmd = cmd_valid && (cmd_ctl == 2'b11);

    // Remember the last accepted address within one log.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            have_prev <= 1'b0;
            last_addr <= '0;
        end else if (mem_wr_valid && mem_wr_ready) begin
            have_prev <= 1'b1;
            last_addr <= mem_wr_addr;
        end
    end

    // R6
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready && !abort_cmd) |=>
        (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    entry_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_ready && have_prev) |->
        (mem_wr_addr == last_addr + ADDR_W'(8)));

    // R4
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (mem_wr_addr[2:0] == 3'b000));

    // R3
    req_in_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> busy);

    // R8
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_cmd) |=> (!busy && done && !mem_wr_valid));

    // R9
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable(entry_count));
endmodule

bind cache_addr_logger cal_checker #(.ADDR_W(48), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ctl      (cmd_word[55:54]),
    .busy         (busy),
    .done         (done),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .entry_count  (entry_count)
);

// File: tb/tb_cache_addr_logger.sv
module tb_cache_addr_logger;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  ctl;
        logic [47:0] base;
        logic [1:0]  pat;
        logic [1:0]  rdy;
        logic [15:0] exp_cnt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b10, 48'h0000_0002_0000, 2'd2, 2'd0, 16'd1025},
        '{2'b10, 48'h0001_2346_0000, 2'd3, 2'd1, 16'd1366},
        '{2'b10, 48'h0000_0004_0000, 2'd0, 2'd1, 16'd1},
        '{2'b01, 48'h00FF_FFFE_0000, 2'd2, 2'd0, 16'd4097},
        '{2'b10, 48'h0000_0008_0000, 2'd1, 2'd1, 16'd4096},
        '{2'b01, 48'h0000_0002_0000, 2'd1, 2'd0, 16'd16384}
    };

    logic        clk;
    logic        rst_n;
    logic        cmd_valid;
    logic [63:0] cmd_word;
    logic [13:0] snap_idx;
    logic        snap_valid;
    logic [63:0] snap_line;
    logic        mem_wr_valid;
    logic        mem_wr_ready;
    logic [47:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        busy;
    logic        done;
    logic [14:0] entry_count;

    int checks = 0;
    int errors = 0;
    int pat_sel = 0;
    int rdy_mode = 0;
    int exp_n = 0;
    int scan_idx = 0;
    int exp_limit = 0;
    int exp_cap = 0;
    int hs_count = 0;
    logic [47:0] exp_base = '0;
    bit term_seen = 0;
    bit abort_sent = 0;
    bit hold_prev = 0;
    logic [47:0] hold_addr = '0;
    logic [63:0] hold_data = '0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic line_valid(int pat, int i);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return (i % 4) == 0;
            default: return (i % 3) == 1;
        endcase
    endfunction

    function automatic logic [63:0] line_addr(int i);
        return 64'h0000_0040_0000_0000 + (64'(i) << 7);
    endfunction

    function automatic logic [63:0] mk_cmd(logic [1:0] ctl, logic [47:0] base);
        return {8'h00, ctl, 6'h00, base};
    endfunction

    assign snap_valid = line_valid(pat_sel, int'(snap_idx));
    assign snap_line  = line_addr(int'(snap_idx));

    cache_addr_logger dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .snap_idx     (snap_idx),
        .snap_valid   (snap_valid),
        .snap_line    (snap_line),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .busy         (busy),
        .done         (done),
        .entry_count  (entry_count)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: sets ready and checks every transfer of the next edge.
    always @(negedge clk) begin
        logic [63:0] exp_data;
        bit          have_exp;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: mem_wr_ready = 1'b1;
            1: mem_wr_ready = lfsr[0];
            default: mem_wr_ready = 1'b0;
        endcase
        if (rst_n === 1'b1) begin
            if (hold_prev && !abort_sent) begin
                chk(mem_wr_valid && mem_wr_addr == hold_addr && mem_wr_data == hold_data,
                    "R6 stalled request held", {16'h0, mem_wr_addr}, {16'h0, hold_addr});
            end
            hold_prev = mem_wr_valid && !mem_wr_ready;
            hold_addr = mem_wr_addr;
            hold_data = mem_wr_data;
            if (mem_wr_valid && mem_wr_ready) begin
                while (scan_idx < exp_limit && !line_valid(pat_sel, scan_idx)) scan_idx++;
                have_exp = 1'b1;
                exp_data = '0;
                if (scan_idx < exp_limit) begin
                    exp_data = line_addr(scan_idx);
                    scan_idx++;
                end else if (exp_n < exp_cap && !term_seen) begin
                    exp_data  = '1;
                    term_seen = 1'b1;
                end else begin
                    have_exp = 1'b0;
                end
                chk(have_exp, "R5 write beyond terminator or full table",
                    {16'h0, mem_wr_addr}, 64'h0);
                chk(mem_wr_data == exp_data, "R3 R5 entry data", mem_wr_data, exp_data);
                chk(mem_wr_addr == exp_base + 48'(exp_n * 8), "R4 entry address",
                    {16'h0, mem_wr_addr}, {16'h0, exp_base + 48'(exp_n * 8)});
                exp_n++;
                hs_count++;
            end
        end
    end

    task automatic send_cmd(input logic [1:0] ctl, input logic [47:0] base);
        cmd_valid = 1'b1;
        cmd_word  = mk_cmd(ctl, base);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic start_log(input logic [1:0] ctl, input logic [47:0] base,
                             input int pat, input int rdy);
        pat_sel    = pat;
        rdy_mode   = rdy;
        exp_base   = base;
        exp_limit  = (ctl == 2'b01) ? 16384 : 4096;
        exp_cap    = (ctl == 2'b01) ? 16384 : 4096;
        exp_n      = 0;
        scan_idx   = 0;
        hs_count   = 0;
        term_seen  = 1'b0;
        abort_sent = 1'b0;
        send_cmd(ctl, base);
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 40000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, "R7 done reached", 64'(done), 64'h1);
    endtask

    task automatic end_checks(input int exp_cnt);
        chk(busy == 1'b0, "R7 busy low with done", 64'(busy), 64'h0);
        chk(entry_count == 15'(exp_cnt), "R1 R7 entry count",
            64'(entry_count), 64'(exp_cnt));
        chk(hs_count == exp_cnt, "R5 accepted writes", 64'(hs_count), 64'(exp_cnt));
        @(negedge clk);
        chk(done == 1'b0, "R7 done lasts one cycle", 64'(done), 64'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [14:0] cnt_before;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_word  = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy after reset", 64'(busy), 64'h0);
        chk(done == 1'b0, "R11 done after reset", 64'(done), 64'h0);
        chk(mem_wr_valid == 1'b0, "R11 no request after reset", 64'(mem_wr_valid), 64'h0);
        chk(entry_count == '0, "R11 count after reset", 64'(entry_count), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven logs covering modes, patterns, back-pressure and full tables.
        for (int v = 0; v < 6; v++) begin
            start_log(VECS[v].ctl, VECS[v].base, int'(VECS[v].pat), int'(VECS[v].rdy));
            wait_done();
            end_checks(int'(VECS[v].exp_cnt));
        end

        // R9 no-op and abort while idle change nothing.
        cnt_before = entry_count;
        send_cmd(2'b00, 48'h0000_0002_0000);
        send_cmd(2'b11, 48'h0);
        for (int k = 0; k < 4; k++) begin
            chk(done == 1'b0 && busy == 1'b0, "R9 idle command no effect",
                64'({done, busy}), 64'h0);
            @(negedge clk);
        end
        chk(entry_count == cnt_before, "R9 count held", 64'(entry_count), 64'(cnt_before));

        // R2 misaligned base rejected.
        send_cmd(2'b10, 48'h0000_0000_8000);
        for (int k = 0; k < 5; k++) begin
            chk(busy == 1'b0 && mem_wr_valid == 1'b0, "R2 misaligned start rejected",
                64'({busy, mem_wr_valid}), 64'h0);
            @(negedge clk);
        end
        chk(entry_count == cnt_before, "R2 count held", 64'(entry_count), 64'(cnt_before));

        // R10 start and no-op while busy are ignored.
        start_log(2'b10, 48'h0000_0006_0000, 2, 1);
        repeat (100) @(negedge clk);
        send_cmd(2'b01, 48'h0000_0020_0000);
        send_cmd(2'b00, 48'h0);
        chk(busy == 1'b1, "R10 log continues", 64'(busy), 64'h1);
        wait_done();
        end_checks(1025);

        // R6 long stall then R8 abort.
        start_log(2'b01, 48'h0000_0010_0000, 1, 2);
        repeat (30) @(negedge clk);
        chk(mem_wr_valid == 1'b1, "R6 request waits for ready", 64'(mem_wr_valid), 64'h1);
        rdy_mode = 1;
        repeat (200) @(negedge clk);
        abort_sent = 1'b1;
        send_cmd(2'b11, 48'h0);
        chk(done == 1'b1, "R8 done after abort", 64'(done), 64'h1);
        chk(busy == 1'b0, "R8 busy low after abort", 64'(busy), 64'h0);
        chk(mem_wr_valid == 1'b0, "R8 request withdrawn", 64'(mem_wr_valid), 64'h0);
        chk(entry_count == 15'(hs_count), "R8 count equals accepted",
            64'(entry_count), 64'(hs_count));
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule